// File: doc/BRIEF.md
# Pause-Width Keyed Frame Transmitter

This block sends one reader-to-card frame by switching a carrier enable off and on. Every bit opens with a short carrier-off pause of fixed length, and the carrier-on interval that follows is long for a coded one and short for a coded zero. The coded bit is the payload bit exclusive-ORed with a keystream bit that an outside generator supplies. The block asks that generator to step once at the end of every bit.

All timing is taken from a free-running tick count (`now_ts`) and is never counted locally. The block keeps a single end-of-frame timestamp. On a start request it loads that timestamp with the end of the previous card frame plus the turnaround gap. From then on it adds each pause and each carrier-on interval to the same register. The register is exported, so a receiver can schedule its own slots from the point where this frame ends. With the default parameters, one tick is two thirds of a microsecond. The pause is 30 ticks, a one is 150 ticks in total, a zero is 90 ticks in total, and the gap is 330 ticks.

The controller has five states. ST_IDLE waits for a start. ST_GAP waits out the turnaround. ST_PAUSE holds the carrier off for a bit's pause. ST_MARK holds the carrier on for the bit's value-dependent interval. ST_TAIL holds the closing pause. The transitions are:
- start: ST_IDLE to ST_GAP, on a start with a legal length.
- gap over: ST_GAP to ST_PAUSE.
- pause over: ST_PAUSE to ST_MARK, where the coded bit is decided.
- next bit: ST_MARK to ST_PAUSE, when bits remain.
- last bit: ST_MARK to ST_TAIL, after the final bit.
- finish: ST_TAIL to ST_IDLE, with a done pulse.

Top module: `pw_frame_tx`

## Requirements
- R1: After reset the block is idle: `carrier_en` is 1, and `busy`, `done` and `ks_adv` are 0.
- R2: A start is taken only in idle and only when `bit_count` lies in 1..MAX_BITS. A start with a count of 0 or above MAX_BITS leaves the block idle with the carrier on.
- R3: The first pause begins when `now_ts` reaches `anchor_ts + GAP_TICKS`, with `anchor_ts` sampled with the start.
- R4: Each bit begins with exactly PAUSE_TICKS ticks of `carrier_en` = 0. A frame of N bits has exactly N+1 carrier-off intervals.
- R5: The carrier-on interval of a bit lasts ONE_TICKS - PAUSE_TICKS ticks for a coded 1 and ZERO_TICKS - PAUSE_TICKS ticks for a coded 0.
- R6: Bit i (i = 0 first, up to N-1) is coded as `payload[i]` XOR the `ks_bit` value present when that bit's pause ends.
- R7: `ks_adv` pulses for one cycle at the end of each bit's carrier-on interval, N pulses per frame, and a carrier-off interval always follows it.
- R8: After the last bit, the carrier stays off for PAUSE_TICKS more ticks. `done` is high for the single cycle in which that pause completes, and then the carrier is on and `busy` is 0.
- R9: `end_ts` equals `anchor_ts + GAP_TICKS` after a start. At the end of the frame it equals that value plus the sum of all bit durations plus PAUSE_TICKS.
- R10: A start raised while `busy` is 1 changes neither the frame in progress nor its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| now_ts | input | TS_W | Free-running tick count |
| start | input | 1 | Start request |
| payload | input | MAX_BITS | Frame bits, bit 0 sent first |
| bit_count | input | LEN_W | Number of bits to send |
| anchor_ts | input | TS_W | Tick at which the previous card frame ended |
| ks_bit | input | 1 | Current keystream bit |
| ks_adv | output | 1 | Step request to the keystream generator |
| carrier_en | output | 1 | Carrier enable, 0 during pauses |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |
| end_ts | output | TS_W | Shared end-of-frame timestamp |

## Verification
The bench builds the block with a 16-bit timestamp, a 3-tick pause, 9-tick ones, 6-tick zeros and an 11-tick gap, and keeps the full 23-bit frame width. With these short durations, every frame length from 1 to 23 fits in the run, each with four payload patterns whitened by a bench-owned LFSR. Each frame is timed edge by edge at the carrier. The anchor is placed both so that the gap runs in full and so that it expires on the first possible cycle. Busy-time starts and out-of-range lengths are also applied.

// File: rtl/pw_frame_tx_pkg.sv
package pw_frame_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_PAUSE,
        ST_MARK,
        ST_TAIL
    } tx_state_e;
endpackage

// File: rtl/pw_deadline.sv
module pw_deadline #(
    parameter int TS_W        = 32,
    parameter int GAP_TICKS   = 330,
    parameter int PAUSE_TICKS = 30,
    parameter int ONE_TICKS   = 150,
    parameter int ZERO_TICKS  = 90
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TS_W-1:0] now_ts,
    input  logic [TS_W-1:0] anchor_ts,
    input  logic            ld_gap,
    input  logic            add_pause,
    input  logic            add_mark,
    input  logic            mark_one,
    output logic [TS_W-1:0] end_ts,
    output logic            reached
);
    localparam logic [TS_W-1:0] GAP_T  = TS_W'(GAP_TICKS);
    localparam logic [TS_W-1:0] PAU_T  = TS_W'(PAUSE_TICKS);
    localparam logic [TS_W-1:0] ONE_ON = TS_W'(ONE_TICKS - PAUSE_TICKS);
    localparam logic [TS_W-1:0] ZER_ON = TS_W'(ZERO_TICKS - PAUSE_TICKS);

    logic [TS_W-1:0] end_q;
    logic [TS_W-1:0] diff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            end_q <= '0;
        end else if (ld_gap) begin
            end_q <= anchor_ts + GAP_T;
        end else if (add_pause) begin
            end_q <= end_q + PAU_T;
        end else if (add_mark) begin
            end_q <= end_q + (mark_one ? ONE_ON : ZER_ON);
        end
    end

    // wrap-safe: deadline reached once now - deadline is non-negative
    always_comb begin
        diff    = now_ts - end_q;
        reached = ~diff[TS_W-1];
    end

    assign end_ts = end_q;

    AST_GAP_ANCHOR: assert property (@(posedge clk) disable iff (!rst_n)
        ld_gap |=> end_ts == $past(anchor_ts) + GAP_T); // R3
    AST_PAUSE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (add_pause && !ld_gap) |=> end_ts == $past(end_ts) + PAU_T); // R4
    AST_MARK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (add_mark && !ld_gap && !add_pause) |=>
        end_ts == $past(end_ts) + ($past(mark_one) ? ONE_ON : ZER_ON)); // R5
endmodule

// File: rtl/pw_bitsel.sv
module pw_bitsel #(
    parameter int MAX_BITS = 23,
    parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
    input  logic [MAX_BITS-1:0] word,
    input  logic [LEN_W-1:0]    idx,
    input  logic                ks_bit,
    output logic                coded
);
    logic sel;

    always_comb begin
        sel = 1'b0;
        for (int k = 0; k < MAX_BITS; k++) begin
            if (idx == LEN_W'(k)) sel = word[k];
        end
        coded = sel ^ ks_bit;
    end
endmodule

// File: rtl/pw_frame_tx.sv
module pw_frame_tx
    import pw_frame_tx_pkg::*;
#(
    parameter int TS_W        = 32,
    parameter int MAX_BITS    = 23,
    parameter int LEN_W       = $clog2(MAX_BITS + 1),
    parameter int GAP_TICKS   = 330,
    parameter int PAUSE_TICKS = 30,
    parameter int ONE_TICKS   = 150,
    parameter int ZERO_TICKS  = 90
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TS_W-1:0]     now_ts,
    input  logic                start,
    input  logic [MAX_BITS-1:0] payload,
    input  logic [LEN_W-1:0]    bit_count,
    input  logic [TS_W-1:0]     anchor_ts,
    input  logic                ks_bit,
    output logic                ks_adv,
    output logic                carrier_en,
    output logic                busy,
    output logic                done,
    output logic [TS_W-1:0]     end_ts
);
    tx_state_e state_q, state_d;
    logic [MAX_BITS-1:0] payload_q;
    logic [LEN_W-1:0]    len_q;
    logic [LEN_W-1:0]    idx_q;
    logic                reached;
    logic                coded;
    logic                len_ok;
    logic                last_bit;
    logic                ld_gap, add_pause, add_mark;

    pw_deadline #(
        .TS_W(TS_W), .GAP_TICKS(GAP_TICKS), .PAUSE_TICKS(PAUSE_TICKS),
        .ONE_TICKS(ONE_TICKS), .ZERO_TICKS(ZERO_TICKS)
    ) u_deadline (
        .clk(clk), .rst_n(rst_n), .now_ts(now_ts), .anchor_ts(anchor_ts),
        .ld_gap(ld_gap), .add_pause(add_pause), .add_mark(add_mark),
        .mark_one(coded), .end_ts(end_ts), .reached(reached)
    );

    pw_bitsel #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_bitsel (
        .word(payload_q), .idx(idx_q), .ks_bit(ks_bit), .coded(coded)
    );

    assign len_ok   = (bit_count != '0) && (bit_count <= LEN_W'(MAX_BITS));
    assign last_bit = (idx_q == len_q - LEN_W'(1));

    // state register and frame registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            payload_q <= '0;
            len_q     <= '0;
            idx_q     <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start && len_ok) begin
                payload_q <= payload;
                len_q     <= bit_count;
                idx_q     <= '0;
            end else if (state_q == ST_MARK && reached) begin
                idx_q <= idx_q + LEN_W'(1);
            end
        end
    end

    // next state and deadline steps
    always_comb begin
        state_d   = state_q;
        ld_gap    = 1'b0;
        add_pause = 1'b0;
        add_mark  = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start && len_ok) begin
                state_d = ST_GAP;
                ld_gap  = 1'b1;
            end
            ST_GAP: if (reached) begin
                state_d   = ST_PAUSE;
                add_pause = 1'b1;
            end
            ST_PAUSE: if (reached) begin
                state_d  = ST_MARK;
                add_mark = 1'b1;
            end
            ST_MARK: if (reached) begin
                state_d   = last_bit ? ST_TAIL : ST_PAUSE;
                add_pause = 1'b1;
            end
            ST_TAIL: if (reached) begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        carrier_en = 1'b1;
        busy       = 1'b1;
        done       = 1'b0;
        ks_adv     = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_GAP:   ;
            ST_PAUSE: carrier_en = 1'b0;
            ST_MARK:  ks_adv = reached;
            ST_TAIL: begin
                carrier_en = 1'b0;
                done       = reached;
            end
            default:  busy = 1'b0;
        endcase
    end

    AST_BAD_LEN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !len_ok) |=> (!busy && carrier_en)); // R2
    AST_KS_THEN_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ks_adv |=> (!carrier_en && !ks_adv)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && carrier_en && !busy)); // R8
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(len_q) && $stable(payload_q))); // R10
endmodule

// File: tb/pw_frame_tx_test.sv
`timescale 1ns/1ps
module pw_frame_tx_test;
    localparam int TS_W  = 16;
    localparam int MAXB  = 23;
    localparam int LW    = 5;
    localparam int GAP   = 11;
    localparam int PAU   = 3;
    localparam int ONE   = 9;
    localparam int ZER   = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [TS_W-1:0] now_ts = '0;
    logic            start = 1'b0;
    logic [MAXB-1:0] payload = '0;
    logic [LW-1:0]   bit_count = '0;
    logic [TS_W-1:0] anchor_ts = '0;
    logic            ks_bit;
    logic            ks_adv, carrier_en, busy, done;
    logic [TS_W-1:0] end_ts;
    logic [7:0]      lfsr;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    always_ff @(posedge clk) now_ts <= now_ts + 16'd1;

    function automatic logic [7:0] lstep(input logic [7:0] v);
        return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lfsr <= 8'hA5;
        else if (ks_adv) lfsr <= lstep(lfsr);
    end
    assign ks_bit = lfsr[0];

    pw_frame_tx #(
        .TS_W(TS_W), .MAX_BITS(MAXB), .LEN_W(LW), .GAP_TICKS(GAP),
        .PAUSE_TICKS(PAU), .ONE_TICKS(ONE), .ZERO_TICKS(ZER)
    ) uut (
        .clk(clk), .rst_n(rst_n), .now_ts(now_ts), .start(start),
        .payload(payload), .bit_count(bit_count), .anchor_ts(anchor_ts),
        .ks_bit(ks_bit), .ks_adv(ks_adv), .carrier_en(carrier_en),
        .busy(busy), .done(done), .end_ts(end_ts)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_frame(input logic [MAXB-1:0] pl, input int n,
                             input int back, input bit poke);
        int fall_t[0:MAXB];
        int rise_t[0:MAXB];
        int nf, nr, adv, ndone, done_t, it, t0, anc, sum;
        logic prev;
        logic [7:0] m;
        logic e [0:MAXB-1];
        @(negedge clk);
        t0  = int'(now_ts);
        anc = t0 - back;
        m   = lfsr;
        sum = 0;
        for (int i = 0; i < n; i++) begin
            e[i] = pl[i] ^ m[0];
            m    = lstep(m);
            sum += e[i] ? ONE : ZER;
        end
        start     = 1'b1;
        payload   = pl;
        bit_count = LW'(n);
        anchor_ts = TS_W'(anc);
        nf = 0; nr = 0; adv = 0; ndone = 0; done_t = 0; it = 0;
        prev = 1'b1;
        do begin
            @(negedge clk);
            it++;
            if (poke && it == 5) begin
                start     = 1'b1;
                payload   = ~pl;
                bit_count = LW'((n == 1) ? 2 : 1);
                anchor_ts = '0;
            end else begin
                start = 1'b0;
            end
            if (ks_adv) adv++;
            if (done) begin ndone++; done_t = int'(now_ts); end
            if (prev && !carrier_en && nf <= MAXB) begin fall_t[nf] = int'(now_ts); nf++; end
            if (!prev && carrier_en && nr <= MAXB) begin rise_t[nr] = int'(now_ts); nr++; end
            prev = carrier_en;
        end while ((busy || it < 2) && it < 2000);
        start = 1'b0;
        check(nf == n + 1, "R4 pause count", nf, n + 1);
        check(nr == n + 1, "R8 rise count", nr, n + 1);
        if (nf == n + 1 && nr == n + 1) begin
            check(fall_t[0] == anc + GAP + 1, "R3 first pause", fall_t[0], anc + GAP + 1);
            for (int i = 0; i < n; i++) begin
                check(rise_t[i] - fall_t[i] == PAU, "R4 pause width",
                      rise_t[i] - fall_t[i], PAU);
                // R6: coded bit selects the R5 carrier-on length
                check(fall_t[i+1] - rise_t[i] == (e[i] ? ONE - PAU : ZER - PAU),
                      "R5/R6 mark width", fall_t[i+1] - rise_t[i],
                      e[i] ? ONE - PAU : ZER - PAU);
            end
            check(rise_t[n] - fall_t[n] == PAU, "R8 tail pause", rise_t[n] - fall_t[n], PAU);
            check(ndone == 1 && done_t == rise_t[n] - 1, "R8 done pulse", done_t, rise_t[n] - 1);
        end
        check(adv == n, "R7 keystream steps", adv, n);
        check(int'(end_ts) == ((anc + GAP + sum + PAU) & 16'hFFFF), "R9 end stamp",
              int'(end_ts), (anc + GAP + sum + PAU) & 16'hFFFF);
        check(m == lfsr, "R6 keystream position", int'(lfsr), int'(m));
        if (poke) check(!busy && carrier_en, "R10 busy start ignored", busy, 0);
    endtask

    task automatic bad_len(input int cnt);
        @(negedge clk);
        start     = 1'b1;
        payload   = '1;
        bit_count = LW'(cnt);
        anchor_ts = now_ts;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            check(carrier_en && !busy && !ks_adv, "R2 bad length ignored", busy, 0);
        end
    endtask

    initial begin
        #1600000;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(carrier_en && !busy && !done && !ks_adv, "R1 reset state", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(carrier_en && !busy && !done && !ks_adv, "R1 idle after reset", carrier_en, 1);
        bad_len(0);
        bad_len(24);
        bad_len(31);
        for (int n = 1; n <= MAXB; n++) begin
            for (int p = 0; p < 4; p++) begin
                logic [MAXB-1:0] pl;
                case (p)
                    0: pl = '0;
                    1: pl = '1;
                    2: pl = 23'h555555;
                    default: pl = MAXB'(n * 37) ^ 23'h2A5A5A;
                endcase
                run_frame(pl, n, ((n + p) % 2 == 1) ? GAP - 1 : 0, p == 3);
                repeat (2) @(negedge clk);
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule